// File: doc/BRIEF.md
# Data Segment Base and Limit Cache

This block holds the hidden base and limit values that sit behind a processor's segment registers, and turns every segment-relative access into a linear address or a limit fault. Four data segments carry a full 32-bit byte limit that software can raise only through a protected-mode descriptor load. The code and stack segments carry a base but always stay capped at a 64KB limit.

A real-mode selector load only moves the base (selector times sixteen). Any limit that a protected-mode load placed in a data segment therefore survives the return to real mode and every later real-mode reload. This lets real-mode code reach the whole 4GB space through a flat descriptor loaded earlier. Entering VM86 mode or asserting reset pulls every data limit back to 64KB.

Loads and mode changes take effect at the clock edge. A lookup is registered and answers one cycle after it is presented, using the cache contents that were in place before that edge.

Top module: `segCacheUnit`

## Requirements
- R1: After reset every base is 0 and every limit is FFFFh. No response is valid until an access is presented. A data access at offset FFFFh returns address FFFFh, and one at offset 10000h faults.
- R2: In real mode (mode code 0), a load sets the segment base to the 16-bit selector shifted left by four bits and leaves the segment limit unchanged.
- R3: In protected mode (mode code 1), a load of a data segment sets its base from ldDescBase and its limit from ldDescLimit. A descriptor with base 0 and limit FFFFFFFFh gives flat 4GB access.
- R4: An access faults when its offset is greater than the selected limit, and the faulting response carries address 0. Otherwise the response address is base plus offset, modulo 2^32.
- R5: The code segment (index 4) and the stack segment (index 5) always have limit FFFFh, whatever the mode or the descriptor limit supplied. Their base loads like any other: the shifted selector in real or VM86 mode, and the descriptor base in protected mode.
- R6: A data segment keeps a descriptor-loaded limit after the mode returns from protected to real, and keeps it across later real-mode loads of the same segment.
- R7: In the cycle in which the mode input first becomes VM86 (code 2) after being anything else, every data segment limit returns to FFFFh. Loads while in VM86 behave as real-mode loads.
- R8: Each access presented with accValid yields exactly one response with rspValid one cycle later. A load or mode change in the same cycle as an access is not seen by that access.
- R9: Data segments use indices 0 to 3. Indices 6 and 7 are invalid: a load to them changes nothing, and an access to them faults. Mode code 3 behaves as real mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | Operating mode: 0 real, 1 protected, 2 VM86, 3 treated as real |
| ldValid | input | 1 | Load strobe for one segment |
| ldSeg | input | 3 | Segment index of the load |
| ldSelector | input | 16 | Selector value used by real and VM86 loads |
| ldDescBase | input | 32 | Descriptor base used by protected-mode loads |
| ldDescLimit | input | 32 | Descriptor byte limit used by protected-mode data loads |
| accValid | input | 1 | Access request strobe |
| accSeg | input | 3 | Segment index of the access |
| accOffset | input | 32 | Byte offset of the access |
| rspValid | output | 1 | Response valid, one cycle after accValid |
| rspAddr | output | 32 | Linear address, 0 on a fault |
| rspFault | output | 1 | Limit or segment-index fault |

## Verification
The assertions assume that mode, the load inputs and the access inputs are known and change only between rising edges. The VM86 property also assumes that mode is held at a defined value during reset, because it looks two cycles back at the mode input. The bench keeps to these assumptions by driving every input on the falling edge and holding mode at real throughout reset. It moves mode only together with a driven cycle, so each entry into VM86 lines up with a known access. Expected addresses come from the requirement arithmetic (selector times sixteen, descriptor base, offset, 32-bit wrap), not from the design's internal state.

// File: rtl/segCachePkg.sv
package segCachePkg;

  typedef enum logic [1:0] {
    MODE_REAL = 2'd0,
    MODE_PROT = 2'd1,
    MODE_VM86 = 2'd2,
    MODE_RSVD = 2'd3
  } cpuMode_e;

  localparam int MAX_SEG = 8;

  typedef struct packed {
    logic [MAX_SEG-1:0] ldOneHot;
    logic               ldUseDesc;
    logic               clrLimits;
    logic               accEn;
  } segStrobe_t;

endpackage

// File: rtl/segCtrl.sv
module segCtrl
  import segCachePkg::*;
#(
  parameter int NUM_SEG   = 6,
  parameter int SEG_IDX_W = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [1:0]           mode,
  input  logic                 ldValid,
  input  logic [SEG_IDX_W-1:0] ldSeg,
  input  logic                 accValid,
  output segStrobe_t           strobe
);

  localparam logic [SEG_IDX_W-1:0] LAST_SEG = SEG_IDX_W'(NUM_SEG - 1);

  cpuMode_e curMode;
  cpuMode_e prevMode;

  assign curMode = cpuMode_e'(mode);

  // previous mode, used to detect entry into VM86
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevMode <= MODE_REAL;
    else       prevMode <= curMode;
  end

  always_comb begin
    strobe = '0;
    if (ldValid && (ldSeg <= LAST_SEG)) strobe.ldOneHot[ldSeg] = 1'b1;
    strobe.ldUseDesc = (curMode == MODE_PROT);
    strobe.clrLimits = (curMode == MODE_VM86) && (prevMode != MODE_VM86);
    strobe.accEn     = accValid;
  end

endmodule

// File: rtl/segDatapath.sv
module segDatapath
  import segCachePkg::*;
#(
  parameter int NUM_DATA  = 4,
  parameter int ADDR_W    = 32,
  parameter int SEL_W     = 16,
  parameter int SHIFT_W   = 4,
  parameter int SEG_IDX_W = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  segStrobe_t           strobe,
  input  logic [SEL_W-1:0]     ldSelector,
  input  logic [ADDR_W-1:0]    ldDescBase,
  input  logic [ADDR_W-1:0]    ldDescLimit,
  input  logic [SEG_IDX_W-1:0] accSeg,
  input  logic [ADDR_W-1:0]    accOffset,
  output logic                 rspValid,
  output logic [ADDR_W-1:0]    rspAddr,
  output logic                 rspFault
);

  localparam int NUM_SEG = NUM_DATA + 2;
  localparam int PAD_W   = ADDR_W - SEL_W - SHIFT_W;
  localparam logic [ADDR_W-1:0] SMALL_LIMIT = {{(ADDR_W-SEL_W){1'b0}}, {SEL_W{1'b1}}};

  logic [ADDR_W-1:0] realBase;
  logic [ADDR_W-1:0] loadBase;
  logic [ADDR_W-1:0] baseVec  [NUM_SEG];
  logic [ADDR_W-1:0] limitVec [NUM_SEG];
  logic              unusedHiBits;

  assign unusedHiBits = ^strobe.ldOneHot[MAX_SEG-1:NUM_SEG];
  assign realBase     = {{PAD_W{1'b0}}, ldSelector, {SHIFT_W{1'b0}}};
  assign loadBase     = strobe.ldUseDesc ? ldDescBase : realBase;

  for (genvar g = 0; g < NUM_SEG; g++) begin : gSeg
    logic [ADDR_W-1:0] baseR;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                  baseR <= '0;
      else if (strobe.ldOneHot[g]) baseR <= loadBase;
    end
    assign baseVec[g] = baseR;

    if (g < NUM_DATA) begin : gData
      logic [ADDR_W-1:0] limitR;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                                      limitR <= SMALL_LIMIT;
        else if (strobe.clrLimits)                      limitR <= SMALL_LIMIT;
        else if (strobe.ldOneHot[g] && strobe.ldUseDesc) limitR <= ldDescLimit;
      end
      assign limitVec[g] = limitR;
    end else begin : gFixed
      assign limitVec[g] = SMALL_LIMIT;
    end
  end

  logic              selHit;
  logic [ADDR_W-1:0] selBase;
  logic [ADDR_W-1:0] selLimit;
  logic              overLimit;
  logic [ADDR_W-1:0] sumAddr;

  always_comb begin
    selHit   = 1'b0;
    selBase  = '0;
    selLimit = '0;
    for (int i = 0; i < NUM_SEG; i++) begin
      if (accSeg == SEG_IDX_W'(i)) begin
        selHit   = 1'b1;
        selBase  = baseVec[i];
        selLimit = limitVec[i];
      end
    end
  end

  assign overLimit = !selHit || (accOffset > selLimit);
  assign sumAddr   = selBase + accOffset;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspFault <= 1'b0;
      rspAddr  <= '0;
    end else begin
      rspValid <= strobe.accEn;
      if (strobe.accEn) begin
        rspFault <= overLimit;
        rspAddr  <= overLimit ? '0 : sumAddr;
      end
    end
  end

endmodule

// File: rtl/segCacheUnit.sv
module segCacheUnit
  import segCachePkg::*;
#(
  parameter int NUM_DATA  = 4,
  parameter int ADDR_W    = 32,
  parameter int SEL_W     = 16,
  parameter int SHIFT_W   = 4,
  parameter int SEG_IDX_W = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [1:0]           mode,
  input  logic                 ldValid,
  input  logic [SEG_IDX_W-1:0] ldSeg,
  input  logic [SEL_W-1:0]     ldSelector,
  input  logic [ADDR_W-1:0]    ldDescBase,
  input  logic [ADDR_W-1:0]    ldDescLimit,
  input  logic                 accValid,
  input  logic [SEG_IDX_W-1:0] accSeg,
  input  logic [ADDR_W-1:0]    accOffset,
  output logic                 rspValid,
  output logic [ADDR_W-1:0]    rspAddr,
  output logic                 rspFault
);

  localparam int NUM_SEG = NUM_DATA + 2;

  segStrobe_t strobe;

  segCtrl #(
    .NUM_SEG  (NUM_SEG),
    .SEG_IDX_W(SEG_IDX_W)
  ) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .mode    (mode),
    .ldValid (ldValid),
    .ldSeg   (ldSeg),
    .accValid(accValid),
    .strobe  (strobe)
  );

  segDatapath #(
    .NUM_DATA (NUM_DATA),
    .ADDR_W   (ADDR_W),
    .SEL_W    (SEL_W),
    .SHIFT_W  (SHIFT_W),
    .SEG_IDX_W(SEG_IDX_W)
  ) uData (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .ldSelector (ldSelector),
    .ldDescBase (ldDescBase),
    .ldDescLimit(ldDescLimit),
    .accSeg     (accSeg),
    .accOffset  (accOffset),
    .rspValid   (rspValid),
    .rspAddr    (rspAddr),
    .rspFault   (rspFault)
  );

endmodule

// File: rtl/segCacheChecker.sv
module segCacheChecker #(
  parameter int NUM_DATA  = 4,
  parameter int ADDR_W    = 32,
  parameter int SEL_W     = 16,
  parameter int SEG_IDX_W = 3
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [1:0]           mode,
  input logic                 accValid,
  input logic [SEG_IDX_W-1:0] accSeg,
  input logic [ADDR_W-1:0]    accOffset,
  input logic                 rspValid,
  input logic [ADDR_W-1:0]    rspAddr,
  input logic                 rspFault
);

  localparam logic [SEG_IDX_W-1:0] LAST_DATA = SEG_IDX_W'(NUM_DATA - 1);
  localparam logic [SEG_IDX_W-1:0] CODE_IDX  = SEG_IDX_W'(NUM_DATA);
  localparam logic [SEG_IDX_W-1:0] STACK_IDX = SEG_IDX_W'(NUM_DATA + 1);
  localparam logic [ADDR_W-1:0] SMALL_LIMIT = {{(ADDR_W-SEL_W){1'b0}}, {SEL_W{1'b1}}};
  localparam logic [1:0] VM86_CODE = 2'd2;

  AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    accValid |=> rspValid); // R8

  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rstN)
    !accValid |=> !rspValid); // R8

  AST_FAULT_ZERO_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspFault) |-> (rspAddr == '0)); // R4

  AST_BAD_SEG_FAULTS: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && (accSeg > STACK_IDX)) |=> rspFault); // R9

  AST_FIXED_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && ((accSeg == CODE_IDX) || (accSeg == STACK_IDX)) &&
     (accOffset > SMALL_LIMIT)) |=> rspFault); // R5

  AST_VM86_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && (accSeg <= LAST_DATA) && (accOffset > SMALL_LIMIT) &&
     ($past(mode) == VM86_CODE) && ($past(mode, 2) != VM86_CODE)) |=> rspFault); // R7

endmodule

bind segCacheUnit segCacheChecker #(
  .NUM_DATA (NUM_DATA),
  .ADDR_W   (ADDR_W),
  .SEL_W    (SEL_W),
  .SEG_IDX_W(SEG_IDX_W)
) uChecker (
  .clk      (clk),
  .rstN     (rstN),
  .mode     (mode),
  .accValid (accValid),
  .accSeg   (accSeg),
  .accOffset(accOffset),
  .rspValid (rspValid),
  .rspAddr  (rspAddr),
  .rspFault (rspFault)
);

// File: tb/tb_segCacheUnit.sv
module tb_segCacheUnit;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  mode = 2'd0;
  logic        ldValid = 1'b0;
  logic [2:0]  ldSeg = '0;
  logic [15:0] ldSelector = '0;
  logic [31:0] ldDescBase = '0;
  logic [31:0] ldDescLimit = '0;
  logic        accValid = 1'b0;
  logic [2:0]  accSeg = '0;
  logic [31:0] accOffset = '0;
  logic        rspValid;
  logic [31:0] rspAddr;
  logic        rspFault;

  int checks = 0;
  int errors = 0;

  logic [32:0] expQ[$];
  string       tagQ[$];

  always #5 clk = ~clk;

  segCacheUnit dut (
    .clk(clk), .rstN(rstN), .mode(mode),
    .ldValid(ldValid), .ldSeg(ldSeg), .ldSelector(ldSelector),
    .ldDescBase(ldDescBase), .ldDescLimit(ldDescLimit),
    .accValid(accValid), .accSeg(accSeg), .accOffset(accOffset),
    .rspValid(rspValid), .rspAddr(rspAddr), .rspFault(rspFault)
  );

  // driver: sets one cycle of inputs, pushes the expected response
  task automatic drive(input logic doLd, input logic [2:0] lSeg, input logic [15:0] sel,
                       input logic [31:0] dBase, input logic [31:0] dLim,
                       input logic doAcc, input logic [2:0] aSeg, input logic [31:0] off,
                       input logic [31:0] eAddr, input logic eFault, input string tag);
    ldValid     = doLd;
    ldSeg       = lSeg;
    ldSelector  = sel;
    ldDescBase  = dBase;
    ldDescLimit = dLim;
    accValid    = doAcc;
    accSeg      = aSeg;
    accOffset   = off;
    if (doAcc) begin
      expQ.push_back({eFault, eAddr});
      tagQ.push_back(tag);
    end
    @(negedge clk);
  endtask

  task automatic acc(input logic [2:0] aSeg, input logic [31:0] off,
                     input logic [31:0] eAddr, input logic eFault, input string tag);
    drive(1'b0, 3'd0, 16'd0, 32'd0, 32'd0, 1'b1, aSeg, off, eAddr, eFault, tag);
  endtask

  task automatic ld(input logic [2:0] lSeg, input logic [15:0] sel,
                    input logic [31:0] dBase, input logic [31:0] dLim);
    drive(1'b1, lSeg, sel, dBase, dLim, 1'b0, 3'd0, 32'd0, 32'd0, 1'b0, "");
  endtask

  task automatic idleCyc();
    drive(1'b0, 3'd0, 16'd0, 32'd0, 32'd0, 1'b0, 3'd0, 32'd0, 32'd0, 1'b0, "");
  endtask

  // monitor: pops the scoreboard as responses appear
  always @(negedge clk) begin
    if (rstN && rspValid) begin
      checks++;
      if (expQ.size() == 0) begin
        errors++;
        $display("FAIL R8 unexpected response addr=%h fault=%b expected none", rspAddr, rspFault);
      end else begin
        logic [32:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        if ({rspFault, rspAddr} !== e) begin
          errors++;
          $display("FAIL %s: got fault=%b addr=%h expected fault=%b addr=%h",
                   t, rspFault, rspAddr, e[32], e[31:0]);
        end
      end
    end
  end

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checks++;
    if (rspValid !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset rspValid=%b expected 0", rspValid);
    end

    // R1 reset contents
    acc(3'd0, 32'h0000FFFF, 32'h0000FFFF, 1'b0, "R1 data offset FFFF");
    acc(3'd0, 32'h00010000, 32'h0, 1'b1, "R1 data offset 10000");
    acc(3'd4, 32'h0000FFFF, 32'h0000FFFF, 1'b0, "R1 code offset FFFF");

    // R2 real-mode load: base only
    ld(3'd1, 16'h1234, 32'hDEAD0000, 32'hFFFFFFFF);
    acc(3'd1, 32'h00000010, 32'h00012340 + 32'h10, 1'b0, "R2 real base");
    acc(3'd1, 32'h00010000, 32'h0, 1'b1, "R2 limit unchanged");

    // R8 load and access in the same cycle
    drive(1'b1, 3'd2, 16'h2000, 32'd0, 32'd0, 1'b1, 3'd2, 32'h5, 32'h5, 1'b0, "R8 old base seen");
    acc(3'd2, 32'h5, 32'h00020005, 1'b0, "R8 new base next cycle");

    // R3 protected-mode loads
    mode = 2'd1;
    ld(3'd0, 16'h0008, 32'h0, 32'hFFFFFFFF);
    ld(3'd4, 16'h0010, 32'h00100000, 32'hFFFFFFFF);
    ld(3'd3, 16'h0018, 32'h00500000, 32'h00000FFF);
    acc(3'd0, 32'h12345678, 32'h12345678, 1'b0, "R3 flat descriptor");
    acc(3'd3, 32'h00000FFF, 32'h00500FFF, 1'b0, "R4 offset equal to limit");
    acc(3'd3, 32'h00001000, 32'h0, 1'b1, "R4 offset above limit");
    acc(3'd4, 32'h0000FFFF, 32'h0010FFFF, 1'b0, "R5 code desc base");
    acc(3'd4, 32'h00010000, 32'h0, 1'b1, "R5 code limit fixed");

    // R6 persistence in real mode
    mode = 2'd0;
    acc(3'd0, 32'h80000000, 32'h80000000, 1'b0, "R6 limit kept after return");
    ld(3'd0, 16'h0010, 32'h0, 32'h0);
    acc(3'd0, 32'hFFFFFF00, 32'h00000100 + 32'hFFFFFF00, 1'b0, "R4 wrap modulo 2^32");
    acc(3'd0, 32'hFFFFFFFF, 32'h000000FF, 1'b0, "R6 limit kept after real load");
    ld(3'd5, 16'hF000, 32'h0, 32'h0);
    acc(3'd5, 32'h0000FFFF, 32'h000FFFFF, 1'b0, "R5 stack real base");
    acc(3'd5, 32'h00010000, 32'h0, 1'b1, "R5 stack limit fixed");

    // R9 invalid indices and reserved mode
    ld(3'd6, 16'hABCD, 32'h0, 32'h0);
    acc(3'd0, 32'h0, 32'h00000100, 1'b0, "R9 load to index 6 ignored");
    acc(3'd6, 32'h0, 32'h0, 1'b1, "R9 access to index 6 faults");
    acc(3'd7, 32'h10, 32'h0, 1'b1, "R9 access to index 7 faults");
    mode = 2'd3;
    ld(3'd1, 16'h0040, 32'h77770000, 32'hFFFFFFFF);
    acc(3'd1, 32'h20, 32'h00000420, 1'b0, "R9 reserved mode loads as real");
    acc(3'd1, 32'h00010000, 32'h0, 1'b1, "R9 reserved mode keeps limit");

    // raise D1 limit, then R7 VM86 entry
    mode = 2'd1;
    ld(3'd1, 16'h0008, 32'h0, 32'hFFFFFFFF);
    mode = 2'd0;
    acc(3'd1, 32'h00010000, 32'h00010000, 1'b0, "R6 D1 flat in real");
    mode = 2'd2;
    acc(3'd0, 32'h80000000, 32'h80000100, 1'b0, "R8 access at VM86 entry sees old limit");
    acc(3'd0, 32'h00010000, 32'h0, 1'b1, "R7 D0 limit reset");
    acc(3'd1, 32'h00010000, 32'h0, 1'b1, "R7 D1 limit reset");
    ld(3'd0, 16'h0200, 32'h99990000, 32'hFFFFFFFF);
    acc(3'd0, 32'h10, 32'h00002010, 1'b0, "R7 VM86 load as real");
    mode = 2'd0;
    acc(3'd0, 32'h00010000, 32'h0, 1'b1, "R7 limit stays small after VM86");

    idleCyc();
    idleCyc();
    idleCyc();
    checks++;
    if (expQ.size() != 0) begin
      errors++;
      $display("FAIL R8 missing responses: %0d pending expected 0", expQ.size());
    end
    summary();
    $finish;
  end

endmodule